// File: doc/BRIEF.md
# Transmit Jabber and Receive Watchdog Supervisor

This block watches the two directions of an Ethernet MAC for activity that runs too long. On the transmit side it measures how long the transmitter stays active, either in bytes (by counting bit-time ticks) or in wall-clock time (by counting a coarse 100 us tick whose limit depends on the link speed). When the limit is reached it raises a one-cycle jabber event and holds the transmitter off. The host may let the transmitter go at once, or the block releases it after a speed-dependent hold interval.

On the receive side it measures how long the receive carrier stays up in bit times. A carrier that is too long raises a one-cycle watchdog event and blocks reception. Reception returns once the carrier has been quiet for a short, selectable number of bit times. Each direction has its own disable input. The event outputs feed interrupt status logic, and the inhibit outputs gate the MAC data paths.

Top module: `tx_rx_guard_timers`

## Requirements
- R1: In byte mode (`jab_count_bytes`=1), continuous `tx_active` with a `bit_tick` on every cycle raises `tx_block` after exactly 16384 ticks (2048 bytes), and not one tick sooner.
- R2: In time mode (`jab_count_bytes`=0), the cutoff is reached after 270 `time_tick` pulses at 10 Mb/s (`speed_100`=0) and after 27 pulses at 100 Mb/s (`speed_100`=1). With a 100 us tick this is 26.9 to 27 ms and 2.6 to 2.7 ms.
- R3: Dropping `tx_active` before the cutoff clears the transmit count, so a new burst has the full limit again.
- R4: With `unjab_now`=1, `tx_block` is high for exactly one cycle after a jabber timeout.
- R5: With `unjab_now`=0, `tx_block` stays high for 3700 `time_tick` pulses at 10 Mb/s (about 370 ms) or 370 pulses at 100 Mb/s (about 37 ms), counted from the first tick edge after the timeout.
- R6: With `jab_off`=1, no jabber event and no `tx_block` occur however long the transmitter is active. Raising `jab_off` while blocked clears `tx_block` on the next cycle.
- R7: Continuous `carrier_sense` for 18432 bit ticks (2304 byte times) raises `rx_block`, while 18431 ticks do not. Dropping the carrier clears the count.
- R8: After a watchdog timeout, `rx_block` stays high while the carrier is present. It clears once the carrier has been low for 44 bit ticks (`wd_rel_long`=1) or for 20 (`wd_rel_long`=0), and carrier returning during that quiet time restarts the count.
- R9: With `wd_off`=1, no watchdog event and no `rx_block` occur. Raising `wd_off` while blocked clears `rx_block` on the next cycle.
- R10: Each of `jab_event` and `wd_event` is a single-cycle pulse. It rises in the same cycle as its inhibit output.
- R11: While reset is asserted, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One pulse per bit time at the current speed |
| time_tick | input | 1 | One pulse per 100 us |
| tx_active | input | 1 | Transmitter is sending |
| carrier_sense | input | 1 | Receive carrier present |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| jab_off | input | 1 | Disable transmit jabber supervision |
| jab_count_bytes | input | 1 | 1 = byte-count limit, 0 = time limit |
| unjab_now | input | 1 | Release transmitter immediately after timeout |
| wd_off | input | 1 | Disable receive watchdog |
| wd_rel_long | input | 1 | 1 = 44 bit-time release, 0 = 20 bit-time release |
| tx_block | output | 1 | Transmitter inhibited |
| jab_event | output | 1 | One-cycle jabber timeout pulse |
| rx_block | output | 1 | Reception inhibited |
| wd_event | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The jabber cutoff and the receive watchdog cutoff are independent, so both can expire on the same clock edge. The bench provokes this by raising the carrier exactly 2048 bit ticks before the transmitter, so that the byte-mode jabber count and the watchdog count reach their limits together. It then expects both event pulses and both inhibit outputs in that one cycle, and checks that disabling both sides in the next cycle clears both inhibits at once.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic {
    GUARD_RUN  = 1'b0,
    GUARD_HOLD = 1'b1
  } guard_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/guard_rst_sync.sv
module guard_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/guard_counter.sv
module guard_counter #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          hit
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    hit    = inc && !clr && (cnt_q >= (limit - CW'(1)));
    cnt_en = clr || inc;
    if (clr || hit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/jab_guard.sv
module jab_guard
  import guard_pkg::*;
#(
  parameter int CW       = 15,
  parameter int JAB_BITS = 16384,
  parameter int JAB_T10  = 270,
  parameter int JAB_T100 = 27,
  parameter int REL_T10  = 3700,
  parameter int REL_T100 = 370
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic time_tick,
  input  logic tx_active,
  input  logic speed_100,
  input  logic jab_off,
  input  logic jab_count_bytes,
  input  logic unjab_now,
  output logic tx_block,
  output logic jab_event
);

  guard_st_e     st_q, st_d;
  logic          run_clr, run_inc, run_hit;
  logic          hold_clr, hold_inc, hold_hit;
  logic          expire;
  logic          event_q;
  logic [CW-1:0] run_lim, hold_lim;

  always_comb begin
    run_lim  = jab_count_bytes ? CW'(JAB_BITS)
             : (speed_100 ? CW'(JAB_T100) : CW'(JAB_T10));
    hold_lim = speed_100 ? CW'(REL_T100) : CW'(REL_T10);
    run_inc  = (st_q == GUARD_RUN) && tx_active
             && (jab_count_bytes ? bit_tick : time_tick);
    run_clr  = jab_off || !tx_active || (st_q == GUARD_HOLD);
    hold_inc = (st_q == GUARD_HOLD) && time_tick && !unjab_now;
    hold_clr = jab_off || (st_q != GUARD_HOLD);
    expire   = run_hit && !jab_off;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      GUARD_RUN:  if (expire) st_d = GUARD_HOLD;
      GUARD_HOLD: if (jab_off || unjab_now || hold_hit) st_d = GUARD_RUN;
      default:    st_d = GUARD_RUN;
    endcase
  end

  guard_counter #(.CW(CW)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(run_clr), .inc(run_inc),
    .limit(run_lim), .hit(run_hit)
  );

  guard_counter #(.CW(CW)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr), .inc(hold_inc),
    .limit(hold_lim), .hit(hold_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= GUARD_RUN;
      event_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      event_q <= expire;
    end
  end

  assign tx_block  = (st_q == GUARD_HOLD);
  assign jab_event = event_q;

  // R10
  jab_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jab_event |=> !jab_event);

  // R10
  jab_with_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_block) |-> jab_event);

  // R6
  jab_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jab_off |=> (!tx_block && !jab_event));

  // R5
  jab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_block && !unjab_now && !jab_off && !time_tick) |=> tx_block);

  // R4
  jab_unjab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_block && unjab_now) |=> !tx_block);

endmodule

// File: rtl/rx_watchdog.sv
module rx_watchdog
  import guard_pkg::*;
#(
  parameter int CW        = 15,
  parameter int WD_BITS   = 18432,
  parameter int REL_LONG  = 44,
  parameter int REL_SHORT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic carrier_sense,
  input  logic wd_off,
  input  logic wd_rel_long,
  output logic rx_block,
  output logic wd_event
);

  guard_st_e     st_q, st_d;
  logic          run_clr, run_inc, run_hit;
  logic          quiet_clr, quiet_inc, quiet_hit;
  logic          expire;
  logic          event_q;
  logic [CW-1:0] run_lim, quiet_lim;

  always_comb begin
    run_lim   = CW'(WD_BITS);
    quiet_lim = wd_rel_long ? CW'(REL_LONG) : CW'(REL_SHORT);
    run_inc   = (st_q == GUARD_RUN) && carrier_sense && bit_tick;
    run_clr   = wd_off || !carrier_sense || (st_q == GUARD_HOLD);
    quiet_inc = (st_q == GUARD_HOLD) && !carrier_sense && bit_tick;
    quiet_clr = wd_off || carrier_sense || (st_q != GUARD_HOLD);
    expire    = run_hit && !wd_off;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      GUARD_RUN:  if (expire) st_d = GUARD_HOLD;
      GUARD_HOLD: if (wd_off || quiet_hit) st_d = GUARD_RUN;
      default:    st_d = GUARD_RUN;
    endcase
  end

  guard_counter #(.CW(CW)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(run_clr), .inc(run_inc),
    .limit(run_lim), .hit(run_hit)
  );

  guard_counter #(.CW(CW)) u_quiet (
    .clk(clk), .rst_n(rst_n), .clr(quiet_clr), .inc(quiet_inc),
    .limit(quiet_lim), .hit(quiet_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= GUARD_RUN;
      event_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      event_q <= expire;
    end
  end

  assign rx_block = (st_q == GUARD_HOLD);
  assign wd_event = event_q;

  // R10
  wd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_event |=> !wd_event);

  // R10
  wd_with_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_block) |-> wd_event);

  // R9
  wd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_off |=> (!rx_block && !wd_event));

  // R8
  wd_carrier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_block && carrier_sense && !wd_off) |=> rx_block);

endmodule

// File: rtl/tx_rx_guard_timers.sv
module tx_rx_guard_timers
  import guard_pkg::*;
#(
  parameter int BYTE_BITS    = 8,
  parameter int JAB_BYTES    = 2048,
  parameter int WD_BYTES     = 2304,
  parameter int JAB_T10      = 270,
  parameter int JAB_T100     = 27,
  parameter int REL_T10      = 3700,
  parameter int REL_T100     = 370,
  parameter int WD_REL_LONG  = 44,
  parameter int WD_REL_SHORT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic time_tick,
  input  logic tx_active,
  input  logic carrier_sense,
  input  logic speed_100,
  input  logic jab_off,
  input  logic jab_count_bytes,
  input  logic unjab_now,
  input  logic wd_off,
  input  logic wd_rel_long,
  output logic tx_block,
  output logic jab_event,
  output logic rx_block,
  output logic wd_event
);

  localparam int JAB_BITS = JAB_BYTES * BYTE_BITS;
  localparam int WD_BITS  = WD_BYTES * BYTE_BITS;
  localparam int MAX_LIM  = max2(max2(JAB_BITS, WD_BITS),
                                 max2(max2(REL_T10, REL_T100),
                                      max2(max2(JAB_T10, JAB_T100),
                                           max2(WD_REL_LONG, WD_REL_SHORT))));
  localparam int CW       = $clog2(MAX_LIM + 1);

  logic rst_core_n;

  guard_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  jab_guard #(
    .CW(CW), .JAB_BITS(JAB_BITS), .JAB_T10(JAB_T10), .JAB_T100(JAB_T100),
    .REL_T10(REL_T10), .REL_T100(REL_T100)
  ) u_jab (
    .clk(clk), .rst_n(rst_core_n), .bit_tick(bit_tick), .time_tick(time_tick),
    .tx_active(tx_active), .speed_100(speed_100), .jab_off(jab_off),
    .jab_count_bytes(jab_count_bytes), .unjab_now(unjab_now),
    .tx_block(tx_block), .jab_event(jab_event)
  );

  rx_watchdog #(
    .CW(CW), .WD_BITS(WD_BITS), .REL_LONG(WD_REL_LONG), .REL_SHORT(WD_REL_SHORT)
  ) u_wd (
    .clk(clk), .rst_n(rst_core_n), .bit_tick(bit_tick),
    .carrier_sense(carrier_sense), .wd_off(wd_off), .wd_rel_long(wd_rel_long),
    .rx_block(rx_block), .wd_event(wd_event)
  );

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!tx_block && !rx_block && !jab_event && !wd_event));

endmodule

// File: tb/tx_rx_guard_timers_test.sv
module tx_rx_guard_timers_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 190000;

  logic clk, rst_n;
  logic bit_tick, time_tick, tx_active, carrier_sense, speed_100;
  logic jab_off, jab_count_bytes, unjab_now, wd_off, wd_rel_long;
  logic tx_block, jab_event, rx_block, wd_event;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  tx_rx_guard_timers uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .time_tick(time_tick),
    .tx_active(tx_active), .carrier_sense(carrier_sense), .speed_100(speed_100),
    .jab_off(jab_off), .jab_count_bytes(jab_count_bytes), .unjab_now(unjab_now),
    .wd_off(wd_off), .wd_rel_long(wd_rel_long),
    .tx_block(tx_block), .jab_event(jab_event),
    .rx_block(rx_block), .wd_event(wd_event)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int jab_byte_limit();
    return 2048 * 8;
  endfunction

  function automatic int jab_time_limit(input logic spd);
    return spd ? 27 : 270;
  endfunction

  function automatic int jab_release(input logic spd);
    return spd ? 370 : 3700;
  endfunction

  function automatic int wd_limit();
    return 2304 * 8;
  endfunction

  function automatic int wd_release(input logic long_sel);
    return long_sel ? 44 : 20;
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected below %0d", cycles, MAX_CYCLES);
      summary();
      $finish;
    end
  end

  initial begin
    int jb, wb;
    logic seen;
    jb = jab_byte_limit();
    wb = wd_limit();
    rst_n = 1'b0;
    bit_tick = 0; time_tick = 0; tx_active = 0; carrier_sense = 0; speed_100 = 0;
    jab_off = 0; jab_count_bytes = 0; unjab_now = 0; wd_off = 0; wd_rel_long = 0;
    void'($urandom(32'd20240611));

    // R11 reset state
    wait_n(3);
    chk(tx_block, 1'b0, "R11 tx_block in reset");
    chk(rx_block, 1'b0, "R11 rx_block in reset");
    chk(jab_event | wd_event, 1'b0, "R11 events in reset");
    rst_n = 1'b1;
    wait_n(4);

    // R1 byte-mode cutoff, R10 pulse, R5 10 Mb/s hold
    jab_count_bytes = 1; bit_tick = 1; time_tick = 1; tx_active = 1;
    wait_n(jb - 1);
    chk(tx_block, 1'b0, "R1 no block one tick early");
    wait_n(1);
    chk(tx_block, 1'b1, "R1 block at 2048 bytes");
    chk(jab_event, 1'b1, "R10 jab_event with block");
    tx_active = 0;
    wait_n(1);
    chk(jab_event, 1'b0, "R10 jab_event single cycle");
    wait_n(jab_release(1'b0) - 2);
    chk(tx_block, 1'b1, "R5 hold 10M last tick");
    wait_n(1);
    chk(tx_block, 1'b0, "R5 release 10M");

    // R2 time mode 10 Mb/s, R4 host release
    jab_count_bytes = 0; speed_100 = 0; unjab_now = 1; bit_tick = 0; tx_active = 1;
    wait_n(jab_time_limit(1'b0) - 1);
    chk(tx_block, 1'b0, "R2 10M early");
    wait_n(1);
    chk(tx_block, 1'b1, "R2 10M cutoff");
    tx_active = 0;
    wait_n(1);
    chk(tx_block, 1'b0, "R4 immediate release");
    unjab_now = 0;

    // R2 time mode 100 Mb/s, R5 100 Mb/s hold
    speed_100 = 1; tx_active = 1;
    wait_n(jab_time_limit(1'b1) - 1);
    chk(tx_block, 1'b0, "R2 100M early");
    wait_n(1);
    chk(tx_block, 1'b1, "R2 100M cutoff");
    tx_active = 0;
    wait_n(jab_release(1'b1) - 1);
    chk(tx_block, 1'b1, "R5 hold 100M last tick");
    wait_n(1);
    chk(tx_block, 1'b0, "R5 release 100M");

    // R3 early drop clears count, R6 disable while blocked
    jab_count_bytes = 1; bit_tick = 1; tx_active = 1;
    wait_n(jb - 1);
    tx_active = 0;
    wait_n(1);
    chk(tx_block, 1'b0, "R3 no block after gap");
    tx_active = 1;
    wait_n(jb - 1);
    chk(tx_block, 1'b0, "R3 count restarted");
    wait_n(1);
    chk(tx_block, 1'b1, "R1 block on second burst");
    tx_active = 0; jab_off = 1;
    wait_n(1);
    chk(tx_block, 1'b0, "R6 disable releases");
    jab_off = 0;
    wait_n(2);

    // R7 watchdog cutoff, R10, R8 long release
    carrier_sense = 1;
    wait_n(wb - 1);
    chk(rx_block, 1'b0, "R7 no block one tick early");
    wait_n(1);
    chk(rx_block, 1'b1, "R7 block at limit");
    chk(wd_event, 1'b1, "R10 wd_event with block");
    wait_n(1);
    chk(wd_event, 1'b0, "R10 wd_event single cycle");
    wait_n(9);
    chk(rx_block, 1'b1, "R8 held while carrier present");
    carrier_sense = 0; wd_rel_long = 1;
    wait_n(wd_release(1'b1) - 1);
    chk(rx_block, 1'b1, "R8 long window last tick");
    wait_n(1);
    chk(rx_block, 1'b0, "R8 long release");

    // R7 drop clears count, R8 short release with restart
    wd_rel_long = 0; carrier_sense = 1;
    wait_n(wb - 1);
    carrier_sense = 0;
    wait_n(1);
    chk(rx_block, 1'b0, "R7 no block after drop");
    carrier_sense = 1;
    wait_n(wb - 1);
    chk(rx_block, 1'b0, "R7 count restarted");
    wait_n(1);
    chk(rx_block, 1'b1, "R7 second burst blocks");
    carrier_sense = 0;
    wait_n(10);
    carrier_sense = 1;
    wait_n(1);
    chk(rx_block, 1'b1, "R8 carrier during quiet");
    carrier_sense = 0;
    wait_n(wd_release(1'b0) - 1);
    chk(rx_block, 1'b1, "R8 short window last tick");
    wait_n(1);
    chk(rx_block, 1'b0, "R8 short release");

    // R6 and R9 disabled supervision
    jab_off = 1; wd_off = 1; tx_active = 1; carrier_sense = 1;
    seen = 1'b0;
    for (int i = 0; i < wb + 100; i++) begin
      wait_n(1);
      if (tx_block | jab_event) seen = 1'b1;
    end
    chk(seen, 1'b0, "R6 jab_off suppresses");
    seen = 1'b0;
    chk(rx_block | wd_event, 1'b0, "R9 wd_off suppresses");
    tx_active = 0; carrier_sense = 0; jab_off = 0; wd_off = 0;
    wait_n(2);

    // R10 both timeouts on the same edge; R6 R9 joint release
    carrier_sense = 1;
    wait_n(wb - jb);
    tx_active = 1;
    wait_n(jb - 1);
    chk(tx_block | rx_block, 1'b0, "R10 both quiet before edge");
    wait_n(1);
    chk(jab_event, 1'b1, "R10 jab_event simultaneous");
    chk(wd_event, 1'b1, "R10 wd_event simultaneous");
    chk(tx_block & rx_block, 1'b1, "R10 both blocked");
    jab_off = 1; wd_off = 1;
    wait_n(1);
    chk(tx_block, 1'b0, "R6 joint release");
    chk(rx_block, 1'b0, "R9 joint release");
    tx_active = 0; carrier_sense = 0; jab_off = 0; wd_off = 0;
    wait_n(2);

    // R3 R7 random short bursts never trip
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      tx_active       = 1'($urandom_range(0, 1));
      carrier_sense   = 1'($urandom_range(0, 1));
      bit_tick        = 1'($urandom_range(0, 1));
      time_tick       = 1'($urandom_range(0, 1));
      speed_100       = 1'($urandom_range(0, 1));
      unjab_now       = 1'($urandom_range(0, 1));
      wd_rel_long     = 1'($urandom_range(0, 1));
      jab_count_bytes = 1'b1;
      wait_n(1);
      if (tx_block | rx_block | jab_event | wd_event) seen = 1'b1;
    end
    chk(seen, 1'b0, "R3 R7 random short activity");

    summary();
    $finish;
  end

endmodule